// File: doc/BRIEF.md
# Descriptor DMA Command Controller

This block is the control core of a descriptor-driven DMA engine. It has two transmit queues, high and low, and one receive engine. A processor writes a command word of write-one bits. These bits start or stop each transmit queue, abort transmission, enable reception or abort reception. The block turns each command into per-queue run state and descriptor fetch requests. It watches the command/status word of every descriptor that comes back. From that word it decides whether to move a buffer, end the chain or close the descriptor, and it records what happened in a set of sticky interrupt cause bits.

Memory traffic, the rest of descriptor parsing and the data path sit outside the block. Neighbouring logic answers a fetch request with the descriptor's command/status word. It reports completion of each buffer, and on transmit whether a collision occurred. Stop requests take effect only between frames. Abort requests drop the engine back to idle at once and close no descriptor.

Top module: `dmac_ctrl`

## Requirements
- R1: After reset the command readback, the cause register and the interrupt output are all 0, and neither engine requests a descriptor.
- R2: Writing 1 to a queue's start bit (command bit 4 for high, bit 5 for low) sets that queue's run bit and clears its stop bit (bit 2 high, bit 3 low). The idle transmit engine then fetches from a running queue, and the high queue is preferred whenever both run.
- R3: A command bit written as 0 changes nothing. If start and stop for the same queue are written as 1 together, stop wins: the readback shows stop 1 and start 0.
- R4: A stop on a queue whose frame is in progress lets that frame finish up to its last descriptor (descriptor bit 16). Only then is the queue's transmit-end cause set (cause bit 6 high, bit 7 low). A stop on a running queue that the engine is not serving sets the end cause on the next edge.
- R5: A fetched descriptor whose ownership bit 31 is 0 ends the chain. No descriptor is closed, the queue's run bit is cleared and its transmit-end cause is set.
- R6: Closing a transmit descriptor whose bit 23 is 1 sets that queue's buffer-return cause (cause bit 2 high, bit 3 low).
- R7: A collision report retries the buffer while fewer than retry_limit retries have been made. The next collision closes the descriptor with an error and sets the retry-limit cause (bit 10 high, bit 11 low). A retry_limit of 0 allows unlimited retries.
- R8: Writing the transmit abort bit (bit 6) clears both run bits, and the engine goes idle on the next edge without closing a descriptor. The abort bit reads 1 until the engine is idle and then clears.
- R9: Writing the receive enable bit (bit 0) makes the receive engine fetch. Closing a receive descriptor with bit 23 set raises cause bit 0. A receive descriptor with bit 31 clear raises cause bit 8 and clears receive enable.
- R10: Writing the receive abort bit (bit 1) clears receive enable, and it wins over an enable written in the same word. The receive engine goes idle, and the abort bit reads 1 until then.
- R11: Cause bits are sticky. A write to the cause register clears each bit written as 0 and keeps each bit written as 1.
- R12: irq is the OR of cause bits 4 through 30 that are enabled in irq_mask. Bits 0 to 3 never raise irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 7 | Command word, write-one bits |
| cmd_rdata | output | 7 | Command readback (run, stop, enable, abort pending) |
| retry_limit | input | RETRY_W | Retries allowed per packet, 0 = unlimited |
| tx_fetch_req | output | 1 | Transmit descriptor fetch request |
| tx_fetch_lo | output | 1 | Queue of the request, 0 high, 1 low |
| tx_desc_valid | input | 1 | Transmit descriptor word is present |
| tx_desc_word | input | 32 | Transmit descriptor command/status word |
| tx_xmit | output | 1 | Data path may move the current buffer |
| tx_done | input | 1 | Buffer attempt finished |
| tx_coll | input | 1 | The finished attempt collided |
| tx_retry | output | 1 | Pulse: retransmit the buffer |
| tx_close | output | 1 | Pulse: close the current descriptor |
| tx_close_err | output | 1 | The close carries a retry-limit error |
| rx_fetch_req | output | 1 | Receive descriptor fetch request |
| rx_desc_valid | input | 1 | Receive descriptor word is present |
| rx_desc_word | input | 32 | Receive descriptor command/status word |
| rx_recv | output | 1 | Data path may fill the current buffer |
| rx_done | input | 1 | Receive buffer finished |
| rx_close | output | 1 | Pulse: close the receive descriptor |
| cause_wr | input | 1 | Cause register write strobe |
| cause_wdata | input | 32 | Cause write data, 0 bits clear |
| irq_mask | input | 32 | Interrupt enable per cause bit |
| cause | output | 32 | Sticky interrupt cause bits |
| irq | output | 1 | Summary interrupt |

## Verification
The hardest case to reach is a stop that lands in the middle of a multi-buffer frame. The queue must keep fetching while its run bit already reads 0, and the end cause may appear only after the descriptor carrying the last flag closes. The stimulus starts the low queue and hands over a hardware-owned descriptor without the last flag. It writes the stop while that buffer is in flight, then completes it and supplies a second descriptor with the last flag, checking at each step that no end cause is raised early. A counterpart case stops the low queue while the engine is serving the high queue, where the cause must appear on the next edge.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int CMD_W   = 7;
  localparam int CAUSE_W = 32;
  localparam int DESC_W  = 32;

  // command word bit positions (write-one)
  localparam int C_RX_EN    = 0;
  localparam int C_RX_ABORT = 1;
  localparam int C_STOP_HI  = 2;
  localparam int C_STOP_LO  = 3;
  localparam int C_START_HI = 4;
  localparam int C_START_LO = 5;
  localparam int C_TX_ABORT = 6;

  // descriptor command/status bits decoded here
  localparam int D_OWN  = 31;
  localparam int D_EI   = 23;
  localparam int D_LAST = 16;

  // cause register bit positions
  localparam int K_RX_BUF    = 0;
  localparam int K_TXBUF_HI  = 2;
  localparam int K_TXBUF_LO  = 3;
  localparam int K_TXEND_HI  = 6;
  localparam int K_TXEND_LO  = 7;
  localparam int K_RX_ERR    = 8;
  localparam int K_RLIM_HI   = 10;
  localparam int K_RLIM_LO   = 11;
  localparam int SUM_LO      = 4;
  localparam int SUM_HI      = 30;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_XFER  = 2'd2
  } eng_state_t;

  function automatic logic [CAUSE_W-1:0] cause_next(
    input logic [CAUSE_W-1:0] cur,
    input logic               wr,
    input logic [CAUSE_W-1:0] wdata,
    input logic [CAUSE_W-1:0] set
  );
    return (wr ? (cur & wdata) : cur) | set;
  endfunction

  function automatic logic cause_summary(
    input logic [CAUSE_W-1:0] cur,
    input logic [CAUSE_W-1:0] mask
  );
    logic [CAUSE_W-1:0] hit;
    hit = cur & mask;
    return |hit[SUM_HI:SUM_LO];
  endfunction

endpackage

// File: rtl/dmac_cmd_regs.sv
module dmac_cmd_regs
  import dmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             tx_idle,
  input  logic             rx_idle,
  input  logic [1:0]       tx_chain_end,
  input  logic             rx_chain_end,
  output logic [1:0]       run,
  output logic [1:0]       stop_hit,
  output logic             rx_en,
  output logic             abort_tx,
  output logic             abort_rx,
  output logic [CMD_W-1:0] rdata
);

  logic [1:0] wr_start, wr_stop, run_q, stop_q;
  logic       wr_abort_tx, wr_abort_rx, wr_rx_en;
  logic       rx_en_q, abort_tx_q, abort_rx_q;

  assign wr_start    = {2{cmd_wr}} & {cmd_wdata[C_START_LO], cmd_wdata[C_START_HI]};
  assign wr_stop     = {2{cmd_wr}} & {cmd_wdata[C_STOP_LO],  cmd_wdata[C_STOP_HI]};
  assign wr_abort_tx = cmd_wr & cmd_wdata[C_TX_ABORT];
  assign wr_abort_rx = cmd_wr & cmd_wdata[C_RX_ABORT];
  assign wr_rx_en    = cmd_wr & cmd_wdata[C_RX_EN];

  // per-queue run/stop bits; stop wins over start, abort over both
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      stop_q <= '0;
    end else begin
      for (int q = 0; q < 2; q++) begin
        if (wr_abort_tx || wr_stop[q]) run_q[q] <= 1'b0;
        else if (wr_start[q])          run_q[q] <= 1'b1;
        else if (tx_chain_end[q])      run_q[q] <= 1'b0;
        if (wr_stop[q])       stop_q[q] <= 1'b1;
        else if (wr_start[q]) stop_q[q] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q    <= 1'b0;
      abort_tx_q <= 1'b0;
      abort_rx_q <= 1'b0;
    end else begin
      if (wr_abort_rx)       rx_en_q <= 1'b0;
      else if (wr_rx_en)     rx_en_q <= 1'b1;
      else if (rx_chain_end) rx_en_q <= 1'b0;
      if (wr_abort_tx)  abort_tx_q <= 1'b1;
      else if (tx_idle) abort_tx_q <= 1'b0;
      if (wr_abort_rx)  abort_rx_q <= 1'b1;
      else if (rx_idle) abort_rx_q <= 1'b0;
    end
  end

  assign run      = run_q;
  assign stop_hit = wr_stop & run_q;
  assign rx_en    = rx_en_q;
  assign abort_tx = abort_tx_q;
  assign abort_rx = abort_rx_q;

  always_comb begin
    rdata             = '0;
    rdata[C_RX_EN]    = rx_en_q;
    rdata[C_RX_ABORT] = abort_rx_q;
    rdata[C_STOP_HI]  = stop_q[0];
    rdata[C_STOP_LO]  = stop_q[1];
    rdata[C_START_HI] = run_q[0];
    rdata[C_START_LO] = run_q[1];
    rdata[C_TX_ABORT] = abort_tx_q;
  end

  a_r3_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_wdata[C_STOP_HI] && cmd_wdata[C_START_HI]) |=> (!run_q[0] && stop_q[0]));

  a_r8_abort_held: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_tx_q && !tx_idle) |=> abort_tx_q);

endmodule

// File: rtl/dmac_tx_engine.sv
module dmac_tx_engine
  import dmac_pkg::*;
#(
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         run,
  input  logic [1:0]         stop_hit,
  input  logic               abort,
  input  logic [RETRY_W-1:0] retry_limit,
  input  logic               desc_valid,
  input  logic [DESC_W-1:0]  desc_word,
  input  logic               done,
  input  logic               coll,
  output logic               fetch_req,
  output logic               fetch_lo,
  output logic               xmit,
  output logic               retry_pulse,
  output logic               close,
  output logic               close_err,
  output logic               idle,
  output logic [1:0]         chain_end,
  output logic [1:0]         buf_evt,
  output logic [1:0]         end_evt,
  output logic [1:0]         rlim_evt
);

  function automatic logic retry_spent(input logic [RETRY_W-1:0] cnt,
                                       input logic [RETRY_W-1:0] lim);
    return (lim != '0) && (cnt == lim);
  endfunction

  eng_state_t         state;
  logic               cur_q, in_frame, ei_q, last_q;
  logic [RETRY_W-1:0] retry_cnt;

  logic own, fetch_hit, chain_hit, drop_hit, take_hit;
  logic xfer_done, spent, frame_end, park;
  logic unused_desc;

  assign own       = desc_word[D_OWN];
  assign fetch_hit = (state == ENG_FETCH) && desc_valid && !abort;
  assign chain_hit = fetch_hit && !own;
  assign drop_hit  = fetch_hit && own && !in_frame && !run[cur_q];
  assign take_hit  = fetch_hit && own && !drop_hit;
  assign xfer_done = (state == ENG_XFER) && done && !abort;
  assign spent     = retry_spent(retry_cnt, retry_limit);

  assign retry_pulse = xfer_done && coll && !spent;
  assign close       = xfer_done && (!coll || spent);
  assign close_err   = xfer_done && coll && spent;
  assign frame_end   = close && (last_q || close_err);
  assign park        = frame_end && !run[cur_q];

  assign unused_desc = ^{desc_word[30:24], desc_word[22:17], desc_word[15:0]};

  generate
    for (genvar q = 0; q < 2; q++) begin : g_q
      logic on_q;
      assign on_q        = (state != ENG_IDLE) && (cur_q == 1'(q));
      assign chain_end[q] = chain_hit && (cur_q == 1'(q));
      assign buf_evt[q]   = close && ei_q && (cur_q == 1'(q));
      assign rlim_evt[q]  = close_err && (cur_q == 1'(q));
      assign end_evt[q]   = (stop_hit[q] && !on_q) ||
                            ((chain_hit || drop_hit || park) && (cur_q == 1'(q)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      cur_q     <= 1'b0;
      in_frame  <= 1'b0;
      ei_q      <= 1'b0;
      last_q    <= 1'b0;
      retry_cnt <= '0;
    end else if (abort && state != ENG_IDLE) begin
      state    <= ENG_IDLE;
      in_frame <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (!abort && run[0]) begin
            state <= ENG_FETCH; cur_q <= 1'b0; in_frame <= 1'b0;
          end else if (!abort && run[1]) begin
            state <= ENG_FETCH; cur_q <= 1'b1; in_frame <= 1'b0;
          end
        end
        ENG_FETCH: begin
          if (chain_hit || drop_hit) begin
            state    <= ENG_IDLE;
            in_frame <= 1'b0;
          end else if (take_hit) begin
            state     <= ENG_XFER;
            in_frame  <= 1'b1;
            ei_q      <= desc_word[D_EI];
            last_q    <= desc_word[D_LAST];
            retry_cnt <= '0;
          end
        end
        ENG_XFER: begin
          if (retry_pulse) retry_cnt <= retry_cnt + 1'b1;
          if (close) begin
            if (frame_end) begin
              state    <= ENG_IDLE;
              in_frame <= 1'b0;
            end else begin
              state <= ENG_FETCH;
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign fetch_req = (state == ENG_FETCH);
  assign fetch_lo  = cur_q;
  assign xmit      = (state == ENG_XFER);
  assign idle      = (state == ENG_IDLE);

  a_r8_abort_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && state != ENG_IDLE) |=> state == ENG_IDLE);

  a_r4_frame_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (close && !last_q && !close_err) |=> state == ENG_FETCH);

  a_r7_err_needs_limit: assert property (@(posedge clk) disable iff (!rst_n)
    close_err |-> retry_limit != '0);

endmodule

// File: rtl/dmac_rx_engine.sv
module dmac_rx_engine
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              abort,
  input  logic              desc_valid,
  input  logic [DESC_W-1:0] desc_word,
  input  logic              done,
  output logic              fetch_req,
  output logic              recv,
  output logic              close,
  output logic              idle,
  output logic              chain_end,
  output logic              buf_evt
);

  eng_state_t state;
  logic       ei_q, fetch_hit, take_hit;
  logic       unused_desc;

  assign fetch_hit = (state == ENG_FETCH) && desc_valid && !abort;
  assign chain_end = fetch_hit && !desc_word[D_OWN];
  assign take_hit  = fetch_hit && desc_word[D_OWN];
  assign close     = (state == ENG_XFER) && done && !abort;
  assign buf_evt   = close && ei_q;
  assign unused_desc = ^{desc_word[30:24], desc_word[22:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      ei_q  <= 1'b0;
    end else if (abort && state != ENG_IDLE) begin
      state <= ENG_IDLE;
    end else begin
      case (state)
        ENG_IDLE:  if (rx_en && !abort) state <= ENG_FETCH;
        ENG_FETCH: begin
          if (chain_end) state <= ENG_IDLE;
          else if (take_hit) begin
            state <= ENG_XFER;
            ei_q  <= desc_word[D_EI];
          end
        end
        ENG_XFER:  if (close) state <= rx_en ? ENG_FETCH : ENG_IDLE;
        default:   state <= ENG_IDLE;
      endcase
    end
  end

  assign fetch_req = (state == ENG_FETCH);
  assign recv      = (state == ENG_XFER);
  assign idle      = (state == ENG_IDLE);

  a_r10_abort_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && state != ENG_IDLE) |=> state == ENG_IDLE);

endmodule

// File: rtl/dmac_cause.sv
module dmac_cause
  import dmac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] set_vec,
  input  logic               cause_wr,
  input  logic [CAUSE_W-1:0] cause_wdata,
  input  logic [CAUSE_W-1:0] irq_mask,
  output logic [CAUSE_W-1:0] cause,
  output logic               irq
);

  logic [CAUSE_W-1:0] cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_next(cause_q, cause_wr, cause_wdata, set_vec);
  end

  assign cause = cause_q;
  assign irq   = cause_summary(cause_q, irq_mask);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
#(
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [6:0]         cmd_wdata,
  output logic [6:0]         cmd_rdata,
  input  logic [RETRY_W-1:0] retry_limit,
  output logic               tx_fetch_req,
  output logic               tx_fetch_lo,
  input  logic               tx_desc_valid,
  input  logic [31:0]        tx_desc_word,
  output logic               tx_xmit,
  input  logic               tx_done,
  input  logic               tx_coll,
  output logic               tx_retry,
  output logic               tx_close,
  output logic               tx_close_err,
  output logic               rx_fetch_req,
  input  logic               rx_desc_valid,
  input  logic [31:0]        rx_desc_word,
  output logic               rx_recv,
  input  logic               rx_done,
  output logic               rx_close,
  input  logic               cause_wr,
  input  logic [31:0]        cause_wdata,
  input  logic [31:0]        irq_mask,
  output logic [31:0]        cause,
  output logic               irq
);

  logic [1:0] run, stop_hit, tx_chain_end, tx_buf_evt, tx_end_evt, tx_rlim_evt;
  logic       rx_en, abort_tx, abort_rx, tx_idle, rx_idle;
  logic       rx_chain_end, rx_buf_evt;
  logic [CAUSE_W-1:0] set_vec;

  dmac_cmd_regs u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_wr       (cmd_wr),
    .cmd_wdata    (cmd_wdata),
    .tx_idle      (tx_idle),
    .rx_idle      (rx_idle),
    .tx_chain_end (tx_chain_end),
    .rx_chain_end (rx_chain_end),
    .run          (run),
    .stop_hit     (stop_hit),
    .rx_en        (rx_en),
    .abort_tx     (abort_tx),
    .abort_rx     (abort_rx),
    .rdata        (cmd_rdata)
  );

  dmac_tx_engine #(.RETRY_W(RETRY_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .stop_hit    (stop_hit),
    .abort       (abort_tx),
    .retry_limit (retry_limit),
    .desc_valid  (tx_desc_valid),
    .desc_word   (tx_desc_word),
    .done        (tx_done),
    .coll        (tx_coll),
    .fetch_req   (tx_fetch_req),
    .fetch_lo    (tx_fetch_lo),
    .xmit        (tx_xmit),
    .retry_pulse (tx_retry),
    .close       (tx_close),
    .close_err   (tx_close_err),
    .idle        (tx_idle),
    .chain_end   (tx_chain_end),
    .buf_evt     (tx_buf_evt),
    .end_evt     (tx_end_evt),
    .rlim_evt    (tx_rlim_evt)
  );

  dmac_rx_engine u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .abort      (abort_rx),
    .desc_valid (rx_desc_valid),
    .desc_word  (rx_desc_word),
    .done       (rx_done),
    .fetch_req  (rx_fetch_req),
    .recv       (rx_recv),
    .close      (rx_close),
    .idle       (rx_idle),
    .chain_end  (rx_chain_end),
    .buf_evt    (rx_buf_evt)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[K_RX_BUF]   = rx_buf_evt;
    set_vec[K_TXBUF_HI] = tx_buf_evt[0];
    set_vec[K_TXBUF_LO] = tx_buf_evt[1];
    set_vec[K_TXEND_HI] = tx_end_evt[0];
    set_vec[K_TXEND_LO] = tx_end_evt[1];
    set_vec[K_RX_ERR]   = rx_chain_end;
    set_vec[K_RLIM_HI]  = tx_rlim_evt[0];
    set_vec[K_RLIM_LO]  = tx_rlim_evt[1];
  end

  dmac_cause u_cause (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_vec     (set_vec),
    .cause_wr    (cause_wr),
    .cause_wdata (cause_wdata),
    .irq_mask    (irq_mask),
    .cause       (cause),
    .irq         (irq)
  );

  a_r5_chain_drops_run: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_chain_end[0] && !(cmd_wr && cmd_wdata[C_START_HI])) |=> !run[0]);

  a_r6_bufret_raised: assert property (@(posedge clk) disable iff (!rst_n)
    tx_buf_evt[0] |=> cause[K_TXBUF_HI]);

  a_r12_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cause[SUM_HI:SUM_LO] != '0));

endmodule

// File: tb/dmac_ctrl_bench.sv
`timescale 1ns/100ps
module dmac_ctrl_bench;

  localparam int RW = 4;
  localparam logic [31:0] OWN = 32'h8000_0000, EI = 32'h0080_0000, LAST = 32'h0001_0000;
  localparam logic [6:0] RXEN = 7'h01, RXAB = 7'h02, STPH = 7'h04, STPL = 7'h08,
                         STAH = 7'h10, STAL = 7'h20, TXAB = 7'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0; logic [6:0] cmd_wdata = '0; logic [6:0] cmd_rdata;
  logic [RW-1:0] retry_limit = '0;
  logic tx_fetch_req, tx_fetch_lo, tx_xmit, tx_retry, tx_close, tx_close_err;
  logic tx_desc_valid = 0, tx_done = 0, tx_coll = 0; logic [31:0] tx_desc_word = '0;
  logic rx_fetch_req, rx_recv, rx_close;
  logic rx_desc_valid = 0, rx_done = 0; logic [31:0] rx_desc_word = '0;
  logic cause_wr = 0; logic [31:0] cause_wdata = '0, irq_mask = '1; logic [31:0] cause;
  logic irq;

  int n_checks = 0, n_fail = 0, sb_checks = 0, sb_fail = 0;
  logic exp_q[$];

  always #2.5 clk = ~clk;

  dmac_ctrl #(.RETRY_W(RW)) u_dmac_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .retry_limit(retry_limit), .tx_fetch_req(tx_fetch_req), .tx_fetch_lo(tx_fetch_lo),
    .tx_desc_valid(tx_desc_valid), .tx_desc_word(tx_desc_word), .tx_xmit(tx_xmit),
    .tx_done(tx_done), .tx_coll(tx_coll), .tx_retry(tx_retry), .tx_close(tx_close),
    .tx_close_err(tx_close_err), .rx_fetch_req(rx_fetch_req), .rx_desc_valid(rx_desc_valid),
    .rx_desc_word(rx_desc_word), .rx_recv(rx_recv), .rx_done(rx_done), .rx_close(rx_close),
    .cause_wr(cause_wr), .cause_wdata(cause_wdata), .irq_mask(irq_mask), .cause(cause), .irq(irq)
  );

  // scoreboard monitor: every transmit close is compared against the driver's expectation
  always @(negedge clk) begin
    if (rst_n && tx_close) begin
      sb_checks++;
      if (exp_q.size() == 0) begin
        sb_fail++;
        $display("FAIL R7: unexpected close, err=%0b expected none", tx_close_err);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (tx_close_err !== e) begin
          sb_fail++;
          $display("FAIL R7: close err=%0b expected %0b", tx_close_err, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [6:0] v);
    cmd_wr = 1; cmd_wdata = v; step(); cmd_wr = 0; cmd_wdata = '0;
  endtask

  task automatic cause_write(input logic [31:0] v);
    cause_wr = 1; cause_wdata = v; step(); cause_wr = 0; cause_wdata = '0;
  endtask

  task automatic tx_desc(input logic [31:0] w);
    tx_desc_valid = 1; tx_desc_word = w; step(); tx_desc_valid = 0; tx_desc_word = '0;
  endtask

  task automatic rx_desc(input logic [31:0] w);
    rx_desc_valid = 1; rx_desc_word = w; step(); rx_desc_valid = 0; rx_desc_word = '0;
  endtask

  // driver: push the expected close (if any), then report the attempt
  task automatic tx_attempt(input logic c, input logic closes, input logic err);
    if (closes) exp_q.push_back(err);
    tx_done = 1; tx_coll = c; step(); tx_done = 0; tx_coll = 0;
  endtask

  task automatic summary(input int extra);
    $display("[TB] %0d tests run, %0d failed", n_checks + sb_checks + extra,
             n_fail + sb_fail + extra);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary(1);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1", {25'd0, cmd_rdata}, 32'h0);
    chk("R1", cause, 32'h0);
    chk("R1", {30'd0, irq, tx_fetch_req | rx_fetch_req}, 32'h0);

    // R2 start high, fetch begins one edge later
    cmd(STAH);
    chk("R2", {25'd0, cmd_rdata}, 32'h10);
    step();
    chk("R2", {30'd0, tx_fetch_req, tx_fetch_lo}, 32'h2);

    // R6 buffer return on EI close; R12 low cause bits do not interrupt
    tx_desc(OWN | EI | LAST);
    chk("R6", {31'd0, tx_xmit}, 32'h1);
    tx_attempt(0, 1, 0);
    chk("R6", cause, 32'h4);
    chk("R12", {31'd0, irq}, 32'h0);

    // R5 end of chain
    step();
    chk("R5", {31'd0, tx_fetch_req}, 32'h1);
    tx_desc(LAST);
    chk("R5", cause, 32'h44);
    chk("R5", {25'd0, cmd_rdata}, 32'h0);
    chk("R12", {31'd0, irq}, 32'h1);

    // R11 clear by writing 0, keep bits written 1
    cause_write(~32'h40);
    chk("R11", cause, 32'h4);
    cause_write(32'h0);
    chk("R11", cause, 32'h0);

    // R3 stop wins over start written together
    cmd(STAL | STPL);
    chk("R3", {25'd0, cmd_rdata}, 32'h08);
    step();
    chk("R3", {31'd0, tx_fetch_req}, 32'h0);
    chk("R3", cause, 32'h0);

    // R2 start clears stop; R3 zero write changes nothing
    cmd(STAL);
    chk("R2", {25'd0, cmd_rdata}, 32'h20);
    cmd(7'h00);
    chk("R3", {25'd0, cmd_rdata}, 32'h20);
    chk("R2", {30'd0, tx_fetch_req, tx_fetch_lo}, 32'h3);

    // R4 stop mid-frame waits for the last descriptor
    tx_desc(OWN);
    cmd(STPL);
    chk("R4", {25'd0, cmd_rdata}, 32'h08);
    chk("R4", cause, 32'h0);
    tx_attempt(0, 1, 0);
    chk("R4", {31'd0, tx_fetch_req}, 32'h1);
    chk("R4", cause, 32'h0);
    tx_desc(OWN | LAST);
    tx_attempt(0, 1, 0);
    chk("R4", cause, 32'h80);
    step();
    chk("R4", {31'd0, tx_fetch_req}, 32'h0);
    cause_write(32'h0);

    // R2 high preferred; R4 stop of the queue not being served acts at once
    cmd(STAH | STAL);
    chk("R2", {25'd0, cmd_rdata}, 32'h30);
    step();
    chk("R2", {30'd0, tx_fetch_req, tx_fetch_lo}, 32'h2);
    cmd(STPL);
    chk("R4", cause, 32'h80);
    chk("R4", {25'd0, cmd_rdata}, 32'h18);
    // R12 masking
    chk("R12", {31'd0, irq}, 32'h1);
    irq_mask = ~32'h80; #1;
    chk("R12", {31'd0, irq}, 32'h0);
    irq_mask = '1;
    cause_write(32'h0);

    // R7 retry limit 2: two retries then an error close
    retry_limit = 4'd2;
    tx_desc(OWN | EI | LAST);
    tx_attempt(1, 0, 0);
    chk("R7", {31'd0, tx_xmit}, 32'h1);
    tx_attempt(1, 0, 0);
    chk("R7", {31'd0, tx_xmit}, 32'h1);
    chk("R7", cause, 32'h0);
    tx_attempt(1, 1, 1);
    chk("R7", cause, 32'h404);
    cause_write(32'h0);
    chk("R7", {31'd0, tx_fetch_req}, 32'h1);

    // R7 unlimited retries when the limit is 0
    retry_limit = 4'd0;
    tx_desc(OWN | LAST);
    for (int i = 0; i < 20; i++) tx_attempt(1, 0, 0);
    chk("R7", {31'd0, tx_xmit}, 32'h1);
    chk("R7", cause, 32'h0);
    tx_attempt(0, 1, 0);
    chk("R7", cause, 32'h0);

    // R8 abort transmit
    step();
    chk("R8", {31'd0, tx_fetch_req}, 32'h1);
    cmd(TXAB);
    chk("R8", {25'd0, cmd_rdata}, 32'h48);
    step();
    chk("R8", {31'd0, tx_fetch_req}, 32'h0);
    chk("R8", {31'd0, cmd_rdata[6]}, 32'h1);
    step();
    chk("R8", {25'd0, cmd_rdata}, 32'h08);
    chk("R8", cause, 32'h0);
    chk("R8", 32'(exp_q.size()), 32'h0);

    // R9 receive path
    cmd(RXEN);
    chk("R9", {25'd0, cmd_rdata}, 32'h09);
    step();
    chk("R9", {31'd0, rx_fetch_req}, 32'h1);
    rx_desc(OWN | EI);
    chk("R9", {31'd0, rx_recv}, 32'h1);
    rx_done = 1; step(); rx_done = 0;
    chk("R9", cause, 32'h1);
    chk("R9", {31'd0, rx_fetch_req}, 32'h1);
    rx_desc(32'h0);
    chk("R9", cause, 32'h101);
    chk("R9", {25'd0, cmd_rdata}, 32'h08);
    chk("R9", {30'd0, rx_fetch_req, irq}, 32'h1);
    cause_write(32'h0);

    // R10 abort receive wins over enable
    cmd(RXEN);
    step();
    chk("R10", {31'd0, rx_fetch_req}, 32'h1);
    cmd(RXEN | RXAB);
    chk("R10", {25'd0, cmd_rdata}, 32'h0A);
    step();
    chk("R10", {31'd0, rx_fetch_req}, 32'h0);
    step();
    chk("R10", {25'd0, cmd_rdata}, 32'h08);
    chk("R10", cause, 32'h0);

    summary(0);
    $finish;
  end

endmodule